// File: doc/BRIEF.md
# Nonsequential Store Gathering Unit

The unit sits behind one core's store path and coalesces narrow stores into a small pool of line buffers. Each buffer owns one aligned 64-byte region. A store that lands in a region some open buffer already owns is merged into that buffer at its byte position, in whatever order the stores come. A store to an unowned region takes a free buffer. Per-byte valid bits record which bytes hold data. A later write to a byte replaces the earlier value.

A buffer leaves as one payload in three cases: its byte mask fills up, it sits idle for a programmable number of cycles, or a store needs a buffer when none is free. The buffer chosen in the last case is the one written longest ago. A flush request drains every open buffer and then reports completion. A parameter selects the cacheable variant, which has eight buffers, or the uncached variant, which has four. Payloads leave on a valid/ready port that carries the line address, 64 data bytes and a 64-bit byte mask.

Top module: `write_gather`

## Requirements
- R1: The cacheable variant (CACHEABLE=1) holds eight buffers and the uncached variant (CACHEABLE=0) holds four. With the default geometry the unit accepts that many stores to distinct lines without stalling, and the next store to a new line stalls.
- R2: A store address is split into three parts. The line is st_addr_i[31:6]. The 8-byte word within the line is st_addr_i[5:3]. st_addr_i[2:0] is ignored. out_addr_o carries the line with bits [5:0] zero.
- R3: Any number of stores to one line, in any word order, merge into a single buffer while that buffer is open. No two open buffers ever hold the same line.
- R4: Store enable bit b writes st_data_i[8b+7:8b] to line byte 8*word+b. Each line byte n appears at out_data_o[8n+7:8n], and out_mask_o[n] is set once that byte has been written. A later write to the same byte replaces the earlier value.
- R5: A store that completes the byte mask makes the payload valid in the cycle right after it is accepted, with no wait for the timeout.
- R6: With a nonzero tmo_cycles_i of T, a buffer whose last accepted store was at clock edge e presents its payload after edge e+T. Every store merged into the buffer restarts this count.
- R7: A store to an unowned line, when no buffer is free and none is waiting to leave, releases the least recently written buffer. The store stalls (st_ready_o low) until that payload has been accepted. It is then taken in the cycle after the hand-off.
- R8: While out_valid_o is high and out_ready_i is low, the payload holds steady. When several payloads wait, the one whose buffer was allocated earliest leaves first.
- R9: A flush_i pulse releases every open buffer, and they leave in allocation order. Stores stall until the flush completes. flush_done_o pulses for one cycle, one cycle after the last payload is accepted.
- R10: After reset no payload is valid, st_ready_o is high and flush_done_o is low.
- R11: tmo_cycles_i equal to zero disables the idle timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmo_cycles_i | input | TMO_W | Idle cycles before release, 0 = never |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle when high with st_valid_i |
| st_addr_i | input | ADDR_W | Store byte address |
| st_data_i | input | WORD_BYTES*8 | Store data |
| st_be_i | input | WORD_BYTES | Store byte enables |
| flush_i | input | 1 | Drain all buffers (pulse) |
| flush_done_o | output | 1 | One-cycle pulse after a flush drains |
| out_valid_o | output | 1 | Payload available |
| out_ready_i | input | 1 | Downstream takes payload |
| out_addr_o | output | ADDR_W | Line-aligned payload address |
| out_data_o | output | LINE_BYTES*8 | Line data |
| out_mask_o | output | LINE_BYTES | Byte valid mask |

## Verification
The hardest case to reach is pressure eviction. Every buffer must be open, none may be pending, and the buffers must have a write history that is not the same as their allocation order, so that picking the least recently written buffer gives a different answer from picking the oldest allocation. The stimulus turns the timeout off and holds out_ready_i low. It fills all four buffers, rewrites the first one, and then issues a store to a fifth line. It checks that the second buffer is presented while the store is held off, and counts the stall cycles until the store is taken. The flush that follows checks that the remaining buffers leave in allocation order.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    BUF_FREE  = 2'd0,
    BUF_OPEN  = 2'd1,
    BUF_DRAIN = 2'd2
  } buf_state_e;
endpackage

// File: rtl/wg_age.sv
// Relative age tracker: older_q[i][j] set means i was touched before j.
module wg_age #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] touch_i,
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] oldest_o
);
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else begin
      for (int k = 0; k < N; k++) begin
        if (touch_i[k]) begin
          for (int j = 0; j < N; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      oldest_o[i] = cand_i[i];
      for (int j = 0; j < N; j++)
        if (j != i && cand_i[j] && !older_q[i][j]) oldest_o[i] = 1'b0;
    end
  end

  AST_TOUCH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(touch_i)); // R7
  AST_OLDEST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cand_i) |-> $onehot(oldest_o)); // R8
endmodule

// File: rtl/wg_line.sv
module wg_line
  import wg_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int TAG_W      = 26,
  parameter int TMO_W      = 16,
  localparam int WORDS     = LINE_BYTES / WORD_BYTES,
  localparam int WSEL_W    = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic                    wr_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [WSEL_W-1:0]       word_i,
  input  logic [WORD_BYTES*8-1:0] wdata_i,
  input  logic [WORD_BYTES-1:0]   wbe_i,
  input  logic                    drain_i,
  input  logic                    pop_i,
  input  logic [TMO_W-1:0]        tmo_i,
  output buf_state_e              state_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [LINE_BYTES*8-1:0] data_o,
  output logic [LINE_BYTES-1:0]   mask_o
);
  buf_state_e              state_q, state_d;
  logic [TMO_W-1:0]        idle_q;
  logic [TAG_W-1:0]        tag_q;
  logic [LINE_BYTES*8-1:0] data_q;
  logic [LINE_BYTES-1:0]   mask_q, mask_d, wmask;
  logic                    expire;

  always_comb begin
    wmask  = LINE_BYTES'(wbe_i) << (word_i * WORD_BYTES);
    mask_d = (alloc_i ? '0 : mask_q) | wmask;
    expire = (tmo_i != '0) && (idle_q == tmo_i - 1'b1);
    state_d = state_q;
    if (pop_i)                                         state_d = BUF_FREE;
    else if (wr_i)                                     state_d = ((&mask_d) || drain_i) ? BUF_DRAIN : BUF_OPEN;
    else if (state_q == BUF_OPEN && (drain_i || expire)) state_d = BUF_DRAIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUF_FREE;
      idle_q  <= '0;
      tag_q   <= '0;
      mask_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wr_i) begin
        mask_q <= mask_d;
        idle_q <= '0;
      end else if (state_q == BUF_OPEN && idle_q != '1) begin
        idle_q <= idle_q + 1'b1;
      end
      if (alloc_i) tag_q <= tag_i;
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < WORD_BYTES; b++)
          if (wr_i && word_i == WSEL_W'(w) && wbe_i[b])
            data_q[(w*WORD_BYTES+b)*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;
  assign mask_o  = mask_q;

  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> state_q == BUF_FREE); // R3
  AST_MERGE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !alloc_i) |-> state_q == BUF_OPEN); // R3
  AST_POP_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> state_q == BUF_DRAIN); // R8
endmodule

// File: rtl/write_gather.sv
module write_gather
  import wg_pkg::*;
#(
  parameter bit CACHEABLE     = 1'b1,
  parameter int CACHED_BUFS   = 8,
  parameter int UNCACHED_BUFS = 4,
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int WORD_BYTES    = 8,
  parameter int TMO_W         = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TMO_W-1:0]        tmo_cycles_i,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [WORD_BYTES*8-1:0] st_data_i,
  input  logic [WORD_BYTES-1:0]   st_be_i,
  input  logic                    flush_i,
  output logic                    flush_done_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [ADDR_W-1:0]       out_addr_o,
  output logic [LINE_BYTES*8-1:0] out_data_o,
  output logic [LINE_BYTES-1:0]   out_mask_o
);
  localparam int NBUF   = CACHEABLE ? CACHED_BUFS : UNCACHED_BUFS;
  localparam int IDX_W  = $clog2(NBUF);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = OFF_W - WOFF_W;
  localparam int TAG_W  = ADDR_W - OFF_W;

  buf_state_e              st_q   [NBUF];
  logic [TAG_W-1:0]        tag_a  [NBUF];
  logic [LINE_BYTES*8-1:0] data_a [NBUF];
  logic [LINE_BYTES-1:0]   mask_a [NBUF];

  logic [NBUF-1:0] hit_vec, free_vec, open_vec, drain_vec, first_free_vec;
  logic [NBUF-1:0] victim_vec, first_drain_vec, wr_vec, alloc_vec, force_vec, pop_vec;
  logic            hit, any_free, any_drain, st_fire, force_evict;
  logic            flushing_q, done_q, hold_q;
  logic [IDX_W-1:0] hold_idx_q, drain_idx, sel_idx;
  logic [TAG_W-1:0]  st_tag;
  logic [WSEL_W-1:0] st_word;
  logic              unused_low;

  assign st_tag     = st_addr_i[ADDR_W-1:OFF_W];
  assign st_word    = st_addr_i[OFF_W-1:WOFF_W];
  assign unused_low = ^st_addr_i[WOFF_W-1:0];

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      hit_vec[i]        = (st_q[i] == BUF_OPEN) && (tag_a[i] == st_tag);
      free_vec[i]       = (st_q[i] == BUF_FREE);
      open_vec[i]       = (st_q[i] == BUF_OPEN);
      drain_vec[i]      = (st_q[i] == BUF_DRAIN);
      first_free_vec[i] = free_vec[i] && !taken;
      taken             = taken | free_vec[i];
    end
    hit         = |hit_vec;
    any_free    = |free_vec;
    any_drain   = |drain_vec;
    st_ready_o  = !flushing_q && (hit || any_free);
    st_fire     = st_valid_i && st_ready_o;
    wr_vec      = st_fire ? (hit ? hit_vec : first_free_vec) : '0;
    alloc_vec   = (st_fire && !hit) ? first_free_vec : '0;
    force_evict = st_valid_i && !flushing_q && !hit && !any_free && !any_drain;
    force_vec   = force_evict ? victim_vec : '0;
  end

  // Output side: oldest allocation first, locked while the consumer stalls.
  always_comb begin
    drain_idx = '0;
    for (int i = 0; i < NBUF; i++)
      if (first_drain_vec[i]) drain_idx = IDX_W'(i);
    sel_idx     = hold_q ? hold_idx_q : drain_idx;
    out_valid_o = any_drain;
    out_addr_o  = {tag_a[sel_idx], {OFF_W{1'b0}}};
    out_data_o  = data_a[sel_idx];
    out_mask_o  = mask_a[sel_idx];
    pop_vec     = (out_valid_o && out_ready_i) ? (NBUF'(1) << sel_idx) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
      flushing_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      hold_q     <= out_valid_o && !out_ready_i;
      hold_idx_q <= sel_idx;
      done_q     <= flushing_q && !flush_i && (&free_vec);
      if (flush_i)                        flushing_q <= 1'b1;
      else if (flushing_q && (&free_vec)) flushing_q <= 1'b0;
    end
  end

  assign flush_done_o = done_q;

  wg_age #(.N(NBUF)) u_lru (
    .clk_i, .rst_ni, .touch_i(wr_vec), .cand_i(open_vec), .oldest_o(victim_vec)
  );

  wg_age #(.N(NBUF)) u_order (
    .clk_i, .rst_ni, .touch_i(alloc_vec), .cand_i(drain_vec), .oldest_o(first_drain_vec)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    wg_line #(
      .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .TAG_W(TAG_W), .TMO_W(TMO_W)
    ) u_line (
      .clk_i, .rst_ni,
      .alloc_i(alloc_vec[g]),
      .wr_i   (wr_vec[g]),
      .tag_i  (st_tag),
      .word_i (st_word),
      .wdata_i(st_data_i),
      .wbe_i  (st_be_i),
      .drain_i(force_vec[g] | flush_i),
      .pop_i  (pop_vec[g]),
      .tmo_i  (tmo_cycles_i),
      .state_o(st_q[g]),
      .tag_o  (tag_a[g]),
      .data_o (data_a[g]),
      .mask_o (mask_a[g])
    );
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
  AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_addr_o) && $stable(out_mask_o)); // R8
  AST_FORCE_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_evict |=> out_valid_o && !st_ready_o); // R7
  AST_FLUSH_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> (&free_vec)); // R9
endmodule

// File: tb/write_gather_test.sv
module write_gather_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0]  tmo;
  logic         st_valid, st_ready, flush, done, out_valid, out_ready;
  logic [31:0]  st_addr, out_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic [511:0] out_data;
  logic [63:0]  out_mask;

  logic         c_valid, c_ready, c_done, c_out_valid;
  logic [31:0]  c_addr, c_out_addr;
  logic [511:0] c_out_data;
  logic [63:0]  c_out_mask;

  write_gather #(.CACHEABLE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tmo_cycles_i(tmo),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_be_i(st_be), .flush_i(flush), .flush_done_o(done),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_addr_o(out_addr),
    .out_data_o(out_data), .out_mask_o(out_mask)
  );

  write_gather #(.CACHEABLE(1'b1)) uut_c (
    .clk_i(clk), .rst_ni(rst_n), .tmo_cycles_i(16'd0),
    .st_valid_i(c_valid), .st_ready_o(c_ready), .st_addr_i(c_addr),
    .st_data_i(64'h0123_4567_89ab_cdef), .st_be_i(8'hff), .flush_i(1'b0),
    .flush_done_o(c_done), .out_valid_o(c_out_valid), .out_ready_i(1'b0),
    .out_addr_o(c_out_addr), .out_data_o(c_out_data), .out_mask_o(c_out_mask)
  );

  int checks = 0;
  int errors = 0;
  int last_stall = 0;
  logic [511:0] mdl_d;
  logic [63:0]  mdl_m;

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int line, int bidx, int k);
    return 8'((line * 13 + bidx * 5 + k * 29) & 255);
  endfunction

  function automatic logic [63:0] word_data(int line, int word, int k);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = pat(line, word * 8 + b, k);
    return r;
  endfunction

  task automatic model_clear();
    mdl_d = '0;
    mdl_m = '0;
  endtask

  // Starts and ends at a falling edge; the store is taken at the rising edge in between.
  task automatic do_store(input logic [31:0] addr, input logic [63:0] data, input logic [7:0] be);
    st_valid = 1'b1; st_addr = addr; st_data = data; st_be = be;
    last_stall = 0;
    #1;
    while (!st_ready) begin
      @(negedge clk); #1;
      last_stall++;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic store_m(input int line, input int word, input int k, input logic [7:0] be, input int lowoff);
    logic [63:0] d;
    d = word_data(line, word, k);
    do_store(32'(line * 64 + word * 8 + lowoff), d, be);
    for (int b = 0; b < 8; b++)
      if (be[b]) begin
        mdl_d[(word*8+b)*8 +: 8] = d[b*8 +: 8];
        mdl_m[word*8+b] = 1'b1;
      end
  endtask

  task automatic pop_check(input string req, input int line);
    logic [511:0] m;
    m = '0;
    for (int b = 0; b < 64; b++) if (mdl_m[b]) m[b*8 +: 8] = 8'hff;
    out_ready = 1'b1;
    #1;
    check({req, " valid"}, 512'(out_valid), 512'd1);
    check({req, " addr"}, 512'(out_addr), 512'(32'(line * 64)));
    check({req, " mask"}, 512'(out_mask), 512'(mdl_m));
    check({req, " data"}, out_data & m, mdl_d & m);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tmo = 16'(T); st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    flush = 0; out_ready = 0; c_valid = 0; c_addr = 0;
    model_clear();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", 512'(out_valid), 0);
    check("R10 ready", 512'(st_ready), 1);
    check("R10 done", 512'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after", 512'(out_valid), 0);
    check("R10 ready after", 512'(st_ready), 1);

    // R1 eight buffers in the cacheable variant
    for (int i = 0; i < 9; i++) begin
      c_valid = 1'b1; c_addr = 32'((32'h800 + i) * 64);
      #1;
      check(i < 8 ? "R1 accept" : "R1 stall", 512'(c_ready), i < 8 ? 512'd1 : 512'd0);
      @(negedge clk);
    end
    c_valid = 1'b0;

    // R2 R4 sweep of word positions and byte enables, low address bits ignored
    for (int w = 0; w < 8; w++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] be;
        be = (p == 0) ? 8'h01 : (p == 1) ? 8'h80 : 8'h5a;
        model_clear();
        store_m(32'h100 + w, w, p, be, (w + p) % 8);
        repeat (T) @(negedge clk);
        pop_check("R2", 32'h100 + w);
      end
    end

    // R6 timeout edge, then restart on merge
    model_clear();
    store_m(32'h200, 2, 0, 8'hff, 0);
    repeat (T - 1) @(negedge clk);
    #1 check("R6 not yet", 512'(out_valid), 0);
    @(negedge clk);
    #1 check("R6 expired", 512'(out_valid), 1);
    pop_check("R6", 32'h200);
    model_clear();
    store_m(32'h201, 0, 0, 8'hff, 0);
    repeat (3) @(negedge clk);
    store_m(32'h201, 1, 0, 8'h0f, 0);
    repeat (T - 1) @(negedge clk);
    #1 check("R6 restart hold", 512'(out_valid), 0);
    @(negedge clk);
    #1 check("R6 restart expire", 512'(out_valid), 1);
    pop_check("R6 merged", 32'h201);

    // R3 R4 out-of-order merge with overwrite
    model_clear();
    store_m(32'h300, 5, 1, 8'hff, 0);
    store_m(32'h300, 1, 1, 8'hff, 3);
    store_m(32'h300, 5, 2, 8'h0f, 0);
    store_m(32'h300, 3, 1, 8'hc0, 7);
    repeat (T) @(negedge clk);
    pop_check("R3 R4", 32'h300);
    #1 check("R3 single payload", 512'(out_valid), 0);

    // R5 full line released at once
    model_clear();
    for (int n = 0; n < 8; n++) begin
      int wo;
      wo = (n * 3 + 3) % 8;
      store_m(32'h400, wo, n, 8'hff, 0);
      #1 check("R5 valid", 512'(out_valid), n == 7 ? 512'd1 : 512'd0);
    end
    pop_check("R5", 32'h400);

    // R11 zero timeout never expires, flush releases it
    tmo = 16'd0;
    model_clear();
    store_m(32'h500, 0, 0, 8'hff, 0);
    repeat (40) @(negedge clk);
    #1 check("R11 held", 512'(out_valid), 0);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    pop_check("R9 single", 32'h500);
    @(negedge clk);
    #1 check("R9 done single", 512'(done), 1);
    @(negedge clk);

    // R7 pressure eviction picks least recently written, store stalls
    for (int i = 0; i < 4; i++) begin
      store_m(32'h600 + i, 0, 0, 8'hff, 0);
      check("R1 four accepted", 512'(last_stall), 0);
    end
    store_m(32'h600, 1, 0, 8'hff, 0);
    fork
      store_m(32'h604, 0, 0, 8'hff, 0);
      begin
        logic [511:0] m;
        m = '0;
        m[63:0] = word_data(32'h601, 0, 0);
        @(negedge clk); #2;
        check("R7 victim valid", 512'(out_valid), 1);
        check("R7 victim addr", 512'(out_addr), 512'(32'h601 * 64));
        check("R7 victim mask", 512'(out_mask), 512'(64'hff));
        check("R7 victim data", out_data & 512'(64'hffff_ffff_ffff_ffff), m);
        check("R7 store held", 512'(st_ready), 0);
        @(negedge clk); #2;
        check("R8 hold valid", 512'(out_valid), 1);
        check("R8 hold addr", 512'(out_addr), 512'(32'h601 * 64));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    check("R7 stall cycles", 512'(last_stall), 3);

    // R9 R8 flush drains in allocation order
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_clear();
    for (int b = 0; b < 16; b++) begin
      mdl_d[b*8 +: 8] = pat(32'h600, b, 0);
      mdl_m[b] = 1'b1;
    end
    pop_check("R9 first", 32'h600);
    st_valid = 1'b1; st_addr = 32'h700 * 64;
    #1 check("R9 store stalled", 512'(st_ready), 0);
    st_valid = 1'b0;
    for (int i = 2; i < 5; i++) begin
      model_clear();
      for (int b = 0; b < 8; b++) begin
        mdl_d[b*8 +: 8] = pat(32'h600 + i, b, 0);
        mdl_m[b] = 1'b1;
      end
      pop_check("R9 order", 32'h600 + i);
    end
    #1 check("R9 done not early", 512'(done), 0);
    @(negedge clk);
    #1 check("R9 done pulse", 512'(done), 1);
    @(negedge clk);
    #1 check("R9 done one cycle", 512'(done), 0);
    check("R9 ready again", 512'(st_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule